// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects an A bus and a B bus that are each 16 bits wide. The width is split into two 8-bit lanes, and each lane has its own set of controls. A lane can move data in either direction, or it can isolate the two buses from each other. Each lane also keeps two holding registers. One holds a snapshot of the A bus and the other holds a snapshot of the B bus. For each direction a select bit decides what the driven bus carries: the live value from the opposite bus or the held snapshot.

The pads are modelled as separate input, output and drive-enable signals, so the core stays synthesizable. Pad logic at the chip edge joins them into real tri-state pins. Each snapshot is taken when a capture strobe rises. The strobes are sampled on the core clock `clk`, and a capture happens at the clock edge where a strobe is high after having been low at the previous edge. Output enable and direction do not affect capture, so a lane can record data while its outputs are isolated.

The data paths have no valid/ready handshake. A pad bus cannot apply back-pressure, so every lane presents its value continuously and the far side samples it whenever it chooses. Output changes appear in the same cycle as the input change, with no register between control input and pad.

Top module: `xcvr_top`

## Requirements
- R1: A synchronous active-low `rst_n` clears both holding registers of every lane to zero, and it clears the strobe history to low.
- R2: The A holding register of lane h loads `a_in[h]` at a clock edge where `cap_ab[h]` is 1 and was 0 at the previous edge. At every other edge it keeps its value, including while the strobe is held high.
- R3: The B holding register of lane h loads `b_in[h]` at a clock edge where `cap_ba[h]` rises, under the same rule as R2. At every other edge it keeps its value.
- R4: While `oe_n[h]` is 1, neither `a_drv[h]` nor `b_drv[h]` is asserted.
- R5: While `oe_n[h]` is 0, `dir[h]`=1 asserts only `b_drv[h]` and `dir[h]`=0 asserts only `a_drv[h]`.
- R6: `a_drv[h]` and `b_drv[h]` are never 1 together.
- R7: When lane h drives B, `b_out` lane h equals the A holding register if `sel_ab[h]`=1, or the live `a_in` lane h if `sel_ab[h]`=0.
- R8: When lane h drives A, `a_out` lane h equals the B holding register if `sel_ba[h]`=1, or the live `b_in` lane h if `sel_ba[h]`=0.
- R9: Values captured while a lane is isolated are kept, and they are driven out later when the stored-data select is chosen.
- R10: Controls of one lane have no effect on the outputs or holding registers of the other lane.
- R11: An output lane that is not driven reads as zero.
- R12: Captures take place during transceiver mode as well. The bus that is currently the input can be stored in either holding register or in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | Value seen on the A pads |
| b_in | input | 16 | Value seen on the B pads |
| oe_n | input | 2 | Per-lane output enable, active low |
| dir | input | 2 | Per-lane direction (1: toward B, 0: toward A) |
| cap_ab | input | 2 | Per-lane A snapshot strobe, capture on rise |
| cap_ba | input | 2 | Per-lane B snapshot strobe, capture on rise |
| sel_ab | input | 2 | Per-lane B-output source (1: held A, 0: live A) |
| sel_ba | input | 2 | Per-lane A-output source (1: held B, 0: live B) |
| a_out | output | 16 | Value to place on the A pads |
| a_drv | output | 2 | Per-lane A pad drive enable |
| b_out | output | 16 | Value to place on the B pads |
| b_drv | output | 2 | Per-lane B pad drive enable |

## Verification
The bench steps through all sixteen combinations of enable, direction and the two selects in each lane. A wrong decode shows up here as a bus driven while isolated, as both pads enabled at once, or as live data where held data was asked for. Strobes held high across several edges catch a level-sensitive capture, which would follow the bus instead of freezing it. Snapshots taken while isolated and while transceiving in both directions are read back later through the stored select. Toggling one lane while the other holds fixed values exposes any crosstalk between the lanes' controls.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    PATH_ISOLATE = 2'd0,
    PATH_TO_A    = 2'd1,
    PATH_TO_B    = 2'd2
  } path_e;

  function automatic path_e decode_path(input logic oe_n, input logic dir);
    if (oe_n)     return PATH_ISOLATE;
    else if (dir) return PATH_TO_B;
    else          return PATH_TO_A;
  endfunction
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv
);
  logic             load_a, load_b;
  logic [WIDTH-1:0] held_a, held_b;
  logic [WIDTH-1:0] to_b, to_a;
  path_e            path;

  xcvr_rise_det u_rise_ab (.clk(clk), .rst_n(rst_n), .strobe(cap_ab), .rise(load_a));
  xcvr_rise_det u_rise_ba (.clk(clk), .rst_n(rst_n), .strobe(cap_ba), .rise(load_b));

  xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .load(load_a), .d(a_in), .q(held_a));
  xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .load(load_b), .d(b_in), .q(held_b));

  // plain 2:1 selects steered only by the select bit
  assign to_b = sel_ab ? held_a : a_in;
  assign to_a = sel_ba ? held_b : b_in;

  always_comb begin
    path  = decode_path(oe_n, dir);
    a_drv = (path == PATH_TO_A);
    b_drv = (path == PATH_TO_B);
    a_out = a_drv ? to_a : '0;
    b_out = b_drv ? to_b : '0;
  end
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANE_W*LANES-1:0]  a_in,
  input  logic [LANE_W*LANES-1:0]  b_in,
  input  logic [LANES-1:0]         oe_n,
  input  logic [LANES-1:0]         dir,
  input  logic [LANES-1:0]         cap_ab,
  input  logic [LANES-1:0]         cap_ba,
  input  logic [LANES-1:0]         sel_ab,
  input  logic [LANES-1:0]         sel_ba,
  output logic [LANE_W*LANES-1:0]  a_out,
  output logic [LANES-1:0]         a_drv,
  output logic [LANE_W*LANES-1:0]  b_out,
  output logic [LANES-1:0]         b_drv
);
  localparam int BUS_W = LANE_W * LANES;

  logic [BUS_W-1:0] a_out_w, b_out_w;

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    xcvr_lane #(.WIDTH(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_in   (a_in[h*LANE_W +: LANE_W]),
      .b_in   (b_in[h*LANE_W +: LANE_W]),
      .oe_n   (oe_n[h]),
      .dir    (dir[h]),
      .cap_ab (cap_ab[h]),
      .cap_ba (cap_ba[h]),
      .sel_ab (sel_ab[h]),
      .sel_ba (sel_ba[h]),
      .a_out  (a_out_w[h*LANE_W +: LANE_W]),
      .a_drv  (a_drv[h]),
      .b_out  (b_out_w[h*LANE_W +: LANE_W]),
      .b_drv  (b_drv[h])
    );
  end

  assign a_out = a_out_w;
  assign b_out = b_out_w;
endmodule

// File: rtl/xcvr_top_chk.sv
module xcvr_top_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANE_W*LANES-1:0] a_in,
  input logic [LANE_W*LANES-1:0] b_in,
  input logic [LANES-1:0]        oe_n,
  input logic [LANES-1:0]        dir,
  input logic [LANES-1:0]        cap_ab,
  input logic [LANES-1:0]        cap_ba,
  input logic [LANES-1:0]        sel_ab,
  input logic [LANES-1:0]        sel_ba,
  input logic [LANE_W*LANES-1:0] a_out,
  input logic [LANES-1:0]        a_drv,
  input logic [LANE_W*LANES-1:0] b_out,
  input logic [LANES-1:0]        b_drv
);
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv & b_drv) == '0); // R6
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_drv | b_drv) & oe_n) == '0); // R4

  for (genvar h = 0; h < LANES; h++) begin : g_chk
    AST_DIR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n[h] |-> (b_drv[h] == dir[h]) && (a_drv[h] == !dir[h])); // R5
    AST_IDLE_A: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drv[h] |-> a_out[h*LANE_W +: LANE_W] == '0); // R11
    AST_IDLE_B: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drv[h] |-> b_out[h*LANE_W +: LANE_W] == '0); // R11
    AST_LIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_drv[h] && !sel_ab[h]) |-> b_out[h*LANE_W +: LANE_W] == a_in[h*LANE_W +: LANE_W]); // R7
    AST_LIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drv[h] && !sel_ba[h]) |-> a_out[h*LANE_W +: LANE_W] == b_in[h*LANE_W +: LANE_W]); // R8
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (b_drv[h] && sel_ab[h] && !cap_ab[h]) |=>
        (!(b_drv[h] && sel_ab[h]) || $stable(b_out[h*LANE_W +: LANE_W]))); // R2
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drv[h] && sel_ba[h] && !cap_ba[h]) |=>
        (!(a_drv[h] && sel_ba[h]) || $stable(a_out[h*LANE_W +: LANE_W]))); // R3
  end
endmodule

bind xcvr_top xcvr_top_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/xcvr_top_test.sv
`timescale 1ns/1ps
module xcvr_top_test;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int BW = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [NL-1:0] oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [BW-1:0] a_out, b_out;
  logic [NL-1:0] a_drv, b_drv;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  always #5 clk = ~clk;

  xcvr_top #(.LANE_W(LW), .LANES(NL)) uut (.*);

  // behavioural reference model
  logic [LW-1:0] m_a [NL];
  logic [LW-1:0] m_b [NL];
  logic [NL-1:0] m_pab = '0, m_pba = '0;

  always @(posedge clk) begin
    for (int h = 0; h < NL; h++) begin
      if (!rst_n) begin
        m_a[h] <= '0; m_b[h] <= '0;
      end else begin
        if (cap_ab[h] && !m_pab[h]) m_a[h] <= a_in[h*LW +: LW];
        if (cap_ba[h] && !m_pba[h]) m_b[h] <= b_in[h*LW +: LW];
      end
    end
    m_pab <= rst_n ? cap_ab : '0;
    m_pba <= rst_n ? cap_ba : '0;
  end

  task automatic compare();
    for (int h = 0; h < NL; h++) begin
      logic ea, eb;
      logic [LW-1:0] eao, ebo;
      ea  = !oe_n[h] && !dir[h];
      eb  = !oe_n[h] && dir[h];
      eao = ea ? (sel_ba[h] ? m_b[h] : b_in[h*LW +: LW]) : '0;
      ebo = eb ? (sel_ab[h] ? m_a[h] : a_in[h*LW +: LW]) : '0;
      checks++;
      if ({a_drv[h], a_out[h*LW +: LW], b_drv[h], b_out[h*LW +: LW]} !== {ea, eao, eb, ebo}) begin
        errors++;
        $display("FAIL %s lane %0d: got a=%0b/%h b=%0b/%h expected a=%0b/%h b=%0b/%h",
                 req, h, a_drv[h], a_out[h*LW +: LW], b_drv[h], b_out[h*LW +: LW], ea, eao, eb, ebo);
      end
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; compare();
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a_in = 16'h1234; b_in = 16'h5678;
    tick(3);
    rst_n = 1'b1;
    // R1: stored selects show cleared registers
    req = "R1"; oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b11; sel_ba = 2'b11; tick(2);

    // R4 R5 R6 R7 R8 R11: all control combos per lane
    for (int c = 0; c < 16; c++) begin
      for (int h = 0; h < NL; h++) begin
        req = "R5";
        oe_n[h] = c[0]; dir[h] = c[1]; sel_ab[h] = c[2]; sel_ba[h] = c[3];
        a_in = a_in + 16'h0101 * (c + 1); b_in = b_in ^ 16'h3c5a;
        tick();
        req = "R7"; a_in = ~a_in; b_in = b_in + 16'h1111; tick();
      end
    end

    // R2: capture on rise only, hold while strobe stays high
    req = "R2"; oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
    a_in = 16'hA55A; cap_ab = 2'b11; tick();
    a_in = 16'h0FF0; tick(3);
    cap_ab = 2'b00; a_in = 16'h1EE1; tick(2);

    // R3 and R12: capture B while B is the input bus
    req = "R3"; dir = 2'b00; sel_ba = 2'b11; b_in = 16'hC33C; cap_ba = 2'b11; tick();
    cap_ba = 2'b00; b_in = 16'h7007; tick(2);
    req = "R12"; dir = 2'b11; sel_ab = 2'b00; a_in = 16'h9696; b_in = 16'h4242;
    cap_ab = 2'b11; cap_ba = 2'b11; tick(); cap_ab = 2'b00; cap_ba = 2'b00; tick();
    dir = 2'b00; sel_ba = 2'b11; tick(); dir = 2'b11; sel_ab = 2'b11; tick();

    // R9: capture during isolation, read back later
    req = "R9"; oe_n = 2'b11; a_in = 16'hBEEF; b_in = 16'hCAFE;
    cap_ab = 2'b11; cap_ba = 2'b11; tick(); cap_ab = 2'b00; cap_ba = 2'b00;
    a_in = 16'h0000; b_in = 16'hFFFF; tick(3);
    oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; tick(2);
    dir = 2'b00; sel_ba = 2'b11; tick(2);

    // R10: toggle lane 1 only, lane 0 fixed
    req = "R10"; oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b01; sel_ba = 2'b00;
    for (int k = 0; k < 6; k++) begin
      oe_n[1] = k[0]; dir[1] = k[1]; cap_ab[1] = k[0]; cap_ba[1] = ~k[0];
      a_in[15:8] = 8'(k * 37); b_in[15:8] = 8'(k * 11);
      tick();
    end
    cap_ab = '0; cap_ba = '0; tick();

    // R1: reset again mid-run
    req = "R1"; rst_n = 1'b0; tick(); rst_n = 1'b1; sel_ab = 2'b11; dir = 2'b11; tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule